// File: doc/BRIEF.md
# Transactional Abort and Fault Normalizer

This unit sits beside the commit stage of a core that supports hardware transactions. It watches whether the committing thread is inside an open transaction and decides what happens to interrupts, head-instruction faults and cache failure replies during that window. Interrupts that arrive inside a transaction are discarded instead of taken. Any fault raised by a head instruction inside a transaction is rewritten as one generic transactional failure. Load replies that report a cache-side transaction failure are turned into an abort cause.

A transactional failure at the commit head starts an abort. The unit raises a fixed-format request to the data cache and holds it until the cache accepts it. The request is physical, strictly ordered, flagged as an abort, aimed at address 0 with a size of 8 bytes, and carries the cause and the transaction identifier. In the same cycle the unit pulses a clear for the start/stop counters kept in both the speculative and the retired transaction-depth trackers.

Top module: `txn_abort_unit`

## Requirements
- R1: While `in_txn` is 1, a pending interrupt yields `irq_drop`=1 and `irq_take`=0 in the same cycle; while `in_txn` is 0 it yields `irq_take`=1 and `irq_drop`=0.
- R2: A head fault (`head_fault` nonzero, not the generic code 4'hF) seen with `in_txn`=1 is reported one cycle later as `flt_code`=4'hF with `flt_cause`=1 (EXCEPTION) and `flt_uid` equal to `head_uid`; outside a transaction the code and cause pass through unchanged and no abort is started.
- R3: A head fault already carrying the generic code 4'hF keeps its `head_cause` unchanged on `flt_cause`.
- R4: Cause encoding is 0 INVALID, 1 EXCEPTION, 2 SIZE, 3 MEMORY, 4 OTHER. A load reply code (0 none, 1 self, 2 remote, 3 other) maps one cycle later to `ld_flt_cause` 2, 3 or 4 with `ld_flt_valid`=1; a code from 4 to 7 instead pulses `resp_err` with no fault.
- R5: A transactional head fault inside a transaction raises `abt_valid` one cycle later with `abt_addr`=0, `abt_size`=8, `abt_phys`=`abt_strict`=`abt_is_abort`=1 and the normalized cause and `head_uid`.
- R6: `ctr_clear` pulses for exactly one cycle, in the cycle the abort request first appears.
- R7: While `abt_ready` is 0 the abort request stays valid with cause and identifier unchanged; it drops in the cycle after the handshake.
- R8: A failure code on a store reply is ignored: no load fault and no `resp_err` result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_txn | input | 1 | Committing thread is inside a transaction |
| irq_pending | input | 1 | An interrupt is waiting to be taken |
| head_valid | input | 1 | Commit head instruction is present |
| head_fault | input | FC_W | Head fault code, 0 = none |
| head_cause | input | 3 | Cause carried by a generic transactional fault |
| head_uid | input | UID_W | Transaction identifier of the head instruction |
| ld_resp_valid | input | 1 | Load reply from the cache |
| ld_resp_code | input | 3 | Load reply failure code |
| ld_resp_uid | input | UID_W | Identifier on the load reply |
| st_resp_valid | input | 1 | Store reply from the cache |
| st_resp_code | input | 3 | Store reply failure code |
| abt_ready | input | 1 | Memory side accepts the abort request |
| irq_take | output | 1 | Service the pending interrupt |
| irq_drop | output | 1 | Clear and discard the pending interrupt |
| flt_valid | output | 1 | Normalized head fault is valid |
| flt_code | output | FC_W | Normalized head fault code |
| flt_cause | output | 3 | Normalized head fault cause |
| flt_uid | output | UID_W | Identifier of the faulting instruction |
| ld_flt_valid | output | 1 | Load reply produced a transactional failure |
| ld_flt_cause | output | 3 | Cause derived from the load reply |
| ld_flt_uid | output | UID_W | Identifier from the load reply |
| resp_err | output | 1 | Load reply carried an unknown failure code |
| abt_valid | output | 1 | Abort request valid |
| abt_addr | output | ADDR_W | Abort request address (always 0) |
| abt_size | output | 4 | Abort request size in bytes (always 8) |
| abt_phys | output | 1 | Request is physically addressed |
| abt_strict | output | 1 | Request is strictly ordered |
| abt_is_abort | output | 1 | Request is an abort |
| abt_cause | output | 3 | Abort cause |
| abt_uid | output | UID_W | Aborted transaction identifier |
| ctr_clear | output | 1 | Clear start/stop counters in both trackers |

## Verification
The hardest situation to reach is an abort request that the memory side refuses for several cycles while new transactional faults keep arriving at the head. The stimulus holds `abt_ready` low after launching an abort, presents a second in-transaction fault with a different identifier and cause, and confirms the held request keeps its original fields and that no second counter clear appears before the handshake.

// File: rtl/txn_abort_unit.sv
module txn_abort_unit #(
  parameter int FC_W        = 4,
  parameter int UID_W       = 16,
  parameter int ADDR_W      = 32,
  parameter logic [FC_W-1:0] TXFAIL_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_txn,
  input  logic              irq_pending,
  input  logic              head_valid,
  input  logic [FC_W-1:0]   head_fault,
  input  logic [2:0]        head_cause,
  input  logic [UID_W-1:0]  head_uid,
  input  logic              ld_resp_valid,
  input  logic [2:0]        ld_resp_code,
  input  logic [UID_W-1:0]  ld_resp_uid,
  input  logic              st_resp_valid,
  input  logic [2:0]        st_resp_code,
  input  logic              abt_ready,
  output logic              irq_take,
  output logic              irq_drop,
  output logic              flt_valid,
  output logic [FC_W-1:0]   flt_code,
  output logic [2:0]        flt_cause,
  output logic [UID_W-1:0]  flt_uid,
  output logic              ld_flt_valid,
  output logic [2:0]        ld_flt_cause,
  output logic [UID_W-1:0]  ld_flt_uid,
  output logic              resp_err,
  output logic              abt_valid,
  output logic [ADDR_W-1:0] abt_addr,
  output logic [3:0]        abt_size,
  output logic              abt_phys,
  output logic              abt_strict,
  output logic              abt_is_abort,
  output logic [2:0]        abt_cause,
  output logic [UID_W-1:0]  abt_uid,
  output logic              ctr_clear
);
  localparam logic [2:0] C_EXCEPTION = 3'd1;
  localparam logic [2:0] C_SIZE      = 3'd2;
  localparam logic [2:0] C_MEMORY    = 3'd3;
  localparam logic [2:0] C_OTHER     = 3'd4;

  assign irq_take = irq_pending & ~in_txn;
  assign irq_drop = irq_pending &  in_txn;

  logic            has_fault, is_generic, in_tx_fault, launch;
  logic [FC_W-1:0] norm_code;
  logic [2:0]      norm_cause;

  assign has_fault   = head_valid && (head_fault != '0);
  assign is_generic  = (head_fault == TXFAIL_CODE);
  assign in_tx_fault = has_fault && in_txn;
  assign norm_code   = in_tx_fault ? TXFAIL_CODE : head_fault;
  assign norm_cause  = (in_tx_fault && !is_generic) ? C_EXCEPTION : head_cause;
  assign launch      = in_tx_fault && !abt_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_code  <= '0;
      flt_cause <= '0;
      flt_uid   <= '0;
    end else begin
      flt_valid <= has_fault;
      if (has_fault) begin
        flt_code  <= norm_code;
        flt_cause <= norm_cause;
        flt_uid   <= head_uid;
      end
    end
  end

  logic [2:0] ld_map;
  logic       ld_fail, ld_bad;
  always_comb begin
    ld_map  = '0;
    ld_fail = 1'b0;
    ld_bad  = 1'b0;
    case (ld_resp_code)
      3'd0: ;
      3'd1: begin ld_map = C_SIZE;   ld_fail = 1'b1; end
      3'd2: begin ld_map = C_MEMORY; ld_fail = 1'b1; end
      3'd3: begin ld_map = C_OTHER;  ld_fail = 1'b1; end
      default: ld_bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_flt_valid <= 1'b0;
      ld_flt_cause <= '0;
      ld_flt_uid   <= '0;
      resp_err     <= 1'b0;
    end else begin
      ld_flt_valid <= ld_resp_valid && ld_fail;
      resp_err     <= ld_resp_valid && ld_bad;
      if (ld_resp_valid && ld_fail) begin
        ld_flt_cause <= ld_map;
        ld_flt_uid   <= ld_resp_uid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abt_valid <= 1'b0;
      abt_cause <= '0;
      abt_uid   <= '0;
      ctr_clear <= 1'b0;
    end else begin
      ctr_clear <= launch;
      if (launch) begin
        abt_valid <= 1'b1;
        abt_cause <= norm_cause;
        abt_uid   <= head_uid;
      end else if (abt_valid && abt_ready) begin
        abt_valid <= 1'b0;
      end
    end
  end

  assign abt_addr     = '0;
  assign abt_size     = 4'd8;
  assign abt_phys     = 1'b1;
  assign abt_strict   = 1'b1;
  assign abt_is_abort = 1'b1;

  a_r1_no_take_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    in_txn |-> !irq_take);

  a_r4_ld_cause_range: assert property (@(posedge clk) disable iff (!rst_n)
    ld_flt_valid |-> (ld_flt_cause >= C_SIZE && ld_flt_cause <= C_OTHER && !resp_err));

  a_r6_clear_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_clear |-> abt_valid);

  a_r6_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_clear |=> !ctr_clear);

  a_r7_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_valid && !abt_ready) |=> (abt_valid && $stable(abt_cause) && $stable(abt_uid)));

  a_r8_store_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st_resp_valid && !ld_resp_valid) |=> (!ld_flt_valid && !resp_err));
endmodule

// File: tb/txn_abort_unit_tb.sv
module txn_abort_unit_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, in_txn, irq_pending, head_valid;
  logic [3:0] head_fault;
  logic [2:0] head_cause;
  logic [15:0] head_uid;
  logic ld_resp_valid, st_resp_valid, abt_ready;
  logic [2:0] ld_resp_code, st_resp_code;
  logic [15:0] ld_resp_uid;
  logic irq_take, irq_drop, flt_valid, ld_flt_valid, resp_err, abt_valid;
  logic [3:0] flt_code, abt_size;
  logic [2:0] flt_cause, ld_flt_cause, abt_cause;
  logic [15:0] flt_uid, ld_flt_uid, abt_uid;
  logic [31:0] abt_addr;
  logic abt_phys, abt_strict, abt_is_abort, ctr_clear;

  txn_abort_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_txn(in_txn), .irq_pending(irq_pending),
    .head_valid(head_valid), .head_fault(head_fault), .head_cause(head_cause),
    .head_uid(head_uid), .ld_resp_valid(ld_resp_valid), .ld_resp_code(ld_resp_code),
    .ld_resp_uid(ld_resp_uid), .st_resp_valid(st_resp_valid), .st_resp_code(st_resp_code),
    .abt_ready(abt_ready), .irq_take(irq_take), .irq_drop(irq_drop),
    .flt_valid(flt_valid), .flt_code(flt_code), .flt_cause(flt_cause), .flt_uid(flt_uid),
    .ld_flt_valid(ld_flt_valid), .ld_flt_cause(ld_flt_cause), .ld_flt_uid(ld_flt_uid),
    .resp_err(resp_err), .abt_valid(abt_valid), .abt_addr(abt_addr), .abt_size(abt_size),
    .abt_phys(abt_phys), .abt_strict(abt_strict), .abt_is_abort(abt_is_abort),
    .abt_cause(abt_cause), .abt_uid(abt_uid), .ctr_clear(ctr_clear));

  int n_run = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    in_txn = 0; irq_pending = 0; head_valid = 0; head_fault = 0; head_cause = 0;
    head_uid = 0; ld_resp_valid = 0; ld_resp_code = 0; ld_resp_uid = 0;
    st_resp_valid = 0; st_resp_code = 0; abt_ready = 1;
  endtask

  task automatic t_reset();
    idle(); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("R5 reset abt_valid", abt_valid, 0);
    chk("R2 reset flt_valid", flt_valid, 0);
    chk("R4 reset ld_flt_valid", ld_flt_valid, 0);
    chk("R6 reset ctr_clear", ctr_clear, 0);
  endtask

  task automatic t_irq();
    irq_pending = 1; in_txn = 0; #1;
    chk("R1 take outside", irq_take, 1);
    chk("R1 no drop outside", irq_drop, 0);
    in_txn = 1; #1;
    chk("R1 drop inside", irq_drop, 1);
    chk("R1 no take inside", irq_take, 0);
    @(negedge clk); idle();
  endtask

  task automatic t_convert();
    in_txn = 1; head_valid = 1; head_fault = 4'h3; head_cause = 3'd0; head_uid = 16'h1234;
    @(negedge clk); idle();
    chk("R2 flt_valid", flt_valid, 1);
    chk("R2 code generic", flt_code, 4'hF);
    chk("R2 cause EXCEPTION", flt_cause, 1);
    chk("R2 uid", flt_uid, 16'h1234);
    chk("R5 abt_valid", abt_valid, 1);
    chk("R5 addr", abt_addr, 0);
    chk("R5 size", abt_size, 8);
    chk("R5 flags", {abt_phys, abt_strict, abt_is_abort}, 3'b111);
    chk("R5 cause", abt_cause, 1);
    chk("R5 uid", abt_uid, 16'h1234);
    chk("R6 clear", ctr_clear, 1);
    @(negedge clk);
    chk("R6 clear one cycle", ctr_clear, 0);
    chk("R7 accepted drops", abt_valid, 0);
  endtask

  task automatic t_hold();
    abt_ready = 0;
    in_txn = 1; head_valid = 1; head_fault = 4'h2; head_uid = 16'h00AA;
    @(negedge clk);
    head_fault = 4'hF; head_cause = 3'd3; head_uid = 16'h00BB;
    chk("R7 valid", abt_valid, 1);
    @(negedge clk);
    head_valid = 0;
    chk("R6 no second clear", ctr_clear, 0);
    repeat (2) @(negedge clk);
    chk("R7 held valid", abt_valid, 1);
    chk("R7 held uid", abt_uid, 16'h00AA);
    chk("R7 held cause", abt_cause, 1);
    abt_ready = 1;
    @(negedge clk);
    chk("R7 released", abt_valid, 0);
    idle(); @(negedge clk);
  endtask

  task automatic t_passthru();
    in_txn = 1; head_valid = 1; head_fault = 4'hF; head_cause = 3'd3; head_uid = 16'h0042;
    @(negedge clk); idle();
    chk("R3 code", flt_code, 4'hF);
    chk("R3 cause kept", flt_cause, 3);
    chk("R3 abort cause", abt_cause, 3);
    @(negedge clk);
    head_valid = 1; head_fault = 4'h5; head_cause = 3'd2; head_uid = 16'h0007;
    @(negedge clk); idle();
    chk("R2 outside code", flt_code, 5);
    chk("R2 outside cause", flt_cause, 2);
    chk("R2 outside no abort", abt_valid, 0);
    chk("R2 outside no clear", ctr_clear, 0);
  endtask

  task automatic t_load();
    for (int c = 1; c <= 3; c++) begin
      ld_resp_valid = 1; ld_resp_code = 3'(c); ld_resp_uid = 16'(c + 16'h10);
      @(negedge clk); idle();
      chk("R4 ld valid", ld_flt_valid, 1);
      chk("R4 ld cause", ld_flt_cause, 32'(c + 1));
      chk("R4 ld uid", ld_flt_uid, 32'(c + 16'h10));
    end
    ld_resp_valid = 1; ld_resp_code = 3'd6;
    @(negedge clk); idle();
    chk("R4 bad code err", resp_err, 1);
    chk("R4 bad code no fault", ld_flt_valid, 0);
    ld_resp_valid = 1; ld_resp_code = 3'd0;
    @(negedge clk); idle();
    chk("R4 none no fault", ld_flt_valid, 0);
  endtask

  task automatic t_store();
    for (int c = 1; c <= 5; c++) begin
      st_resp_valid = 1; st_resp_code = 3'(c);
      @(negedge clk); idle();
      chk("R8 store no fault", ld_flt_valid, 0);
      chk("R8 store no err", resp_err, 0);
    end
  endtask

  initial begin
    fork
      begin
        t_reset(); t_irq(); t_convert(); t_hold(); t_passthru(); t_load(); t_store();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule